// File: doc/BRIEF.md
# Packed SIMD Integer Min/Max Unit

This block takes two operand vectors and, lane by lane, returns the larger or the smaller element of each pair. The lane width, the signed or unsigned reading of each lane, and the choice between maximum and minimum are all set per request. A vector-length bit picks either a 64-bit vector or a full 128-bit vector.

One byte-sliced comparator serves every lane width. Each byte slice produces a greater-than flag and an equal flag. A small combine tree joins these flags into 16-bit and 32-bit lane decisions. The lane-size field then chooses which level of the tree drives the byte multiplexers.

A request is presented with a single-cycle valid strobe. The result, its valid strobe and an undefined-encoding flag appear one clock later. A reserved lane-size code raises the flag and yields an all-zero result.

Top module: `simd_minmax_unit`

## Requirements
- R1: When `in_op`=0 each lane returns the larger element; when `in_op`=1 each lane returns the smaller one.
- R2: `in_size` sets the lane width: 2'b00 gives 8-bit lanes, 2'b01 gives 16-bit lanes and 2'b10 gives 32-bit lanes. Lane k occupies bits [k*W +: W].
- R3: When `in_u`=0 lanes compare as two's-complement signed values; when `in_u`=1 they compare as unsigned values.
- R4: When `in_q`=1 all 128 bits are processed, as two 64-bit halves handled alike.
- R5: Each result lane depends only on the operand elements at the same lane index. No comparison outcome crosses a lane boundary.
- R6: Each result lane is a bit-exact copy of one of the two input elements, with no saturation or change.
- R7: `in_size`=2'b11 is undefined. One cycle later it raises `out_undef` and drives `out_result` to all zeros.
- R8: When `in_q`=0, only operand bits 63:0 are used and result bits 127:64 are zero.
- R9: `out_valid` follows `in_valid` with exactly one clock of latency, and the result is registered with it. A synchronous active-high `rst` clears `out_valid`.
- R10: When the two elements of a lane are equal, that value is returned for both max and min.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_a | input | 128 | First operand vector |
| in_b | input | 128 | Second operand vector |
| in_op | input | 1 | 0 = maximum, 1 = minimum |
| in_size | input | 2 | Lane width code (00 = 8, 01 = 16, 10 = 32, 11 = undefined) |
| in_u | input | 1 | 1 = unsigned compare, 0 = signed compare |
| in_q | input | 1 | 1 = 128-bit vector, 0 = 64-bit vector |
| out_valid | output | 1 | Result strobe, one clock after `in_valid` |
| out_result | output | 128 | Per-lane max/min result |
| out_undef | output | 1 | Reserved lane-size code was requested |

## Verification
Every result, including the undefined flag and the zeroed upper half, is due on the rising edge that follows the request's `in_valid` cycle. The bench applies each request after a falling edge. It reads the outputs at the next falling edge, half a period after that rising edge, so each check looks at exactly the register stage that the request loaded. Idle cycles with `in_valid` low are checked the same way, to show that `out_valid` drops after one clock.

// File: rtl/simd_mm_pkg.sv
package simd_mm_pkg;

    localparam int unsigned SLICE_W = 8;

    typedef enum logic [1:0] {
        SZ_B8  = 2'b00,
        SZ_B16 = 2'b01,
        SZ_B32 = 2'b10,
        SZ_BAD = 2'b11
    } lane_size_e;

    // greater-than / equal pair for a slice or a merged lane
    typedef struct packed {
        logic gt;
        logic eq;
    } cmp_t;

    // true when slice idx holds the most significant byte of its lane
    function automatic logic slice_is_lane_top(lane_size_e sz, int unsigned idx);
        case (sz)
            SZ_B8:   return 1'b1;
            SZ_B16:  return (idx % 2) == 1;
            SZ_B32:  return (idx % 4) == 3;
            default: return 1'b0;
        endcase
    endfunction

    // join a more significant part with a less significant part
    function automatic cmp_t cmp_join(cmp_t hi, cmp_t lo);
        cmp_t r;
        r.gt = hi.gt | (hi.eq & lo.gt);
        r.eq = hi.eq & lo.eq;
        return r;
    endfunction

endpackage

// File: rtl/simd_mm_slice_cmp.sv
module simd_mm_slice_cmp
    import simd_mm_pkg::*;
#(
    parameter int unsigned NSLICE = 16
) (
    input  logic [NSLICE*SLICE_W-1:0] a,
    input  logic [NSLICE*SLICE_W-1:0] b,
    input  lane_size_e                size,
    input  logic                      is_unsigned,
    output cmp_t [NSLICE-1:0]         slice_cmp
);
    for (genvar i = 0; i < NSLICE; i++) begin : g_slice
        logic [SLICE_W-1:0] sa, sb;
        logic               signed_top;
        assign sa         = a[i*SLICE_W +: SLICE_W];
        assign sb         = b[i*SLICE_W +: SLICE_W];
        assign signed_top = !is_unsigned && slice_is_lane_top(size, i);
        always_comb begin
            slice_cmp[i].eq = (sa == sb);
            if (signed_top)
                slice_cmp[i].gt = ($signed(sa) > $signed(sb));
            else
                slice_cmp[i].gt = (sa > sb);
        end
    end
endmodule

// File: rtl/simd_mm_lane_merge.sv
module simd_mm_lane_merge
    import simd_mm_pkg::*;
#(
    parameter int unsigned NSLICE = 16
) (
    input  cmp_t [NSLICE-1:0] slice_cmp,
    input  lane_size_e        size,
    output cmp_t [NSLICE-1:0] lane_cmp
);
    localparam int unsigned N16 = NSLICE / 2;
    localparam int unsigned N32 = NSLICE / 4;

    cmp_t [N16-1:0] c16;
    cmp_t [N32-1:0] c32;

    for (genvar j = 0; j < N16; j++) begin : g_half
        assign c16[j] = cmp_join(slice_cmp[2*j+1], slice_cmp[2*j]);
    end
    for (genvar k = 0; k < N32; k++) begin : g_word
        assign c32[k] = cmp_join(c16[2*k+1], c16[2*k]);
    end

    // broadcast the lane decision back to every slice of the lane
    for (genvar i = 0; i < NSLICE; i++) begin : g_bcast
        always_comb begin
            case (size)
                SZ_B8:   lane_cmp[i] = slice_cmp[i];
                SZ_B16:  lane_cmp[i] = c16[i/2];
                SZ_B32:  lane_cmp[i] = c32[i/4];
                default: lane_cmp[i] = '0;
            endcase
        end
    end
endmodule

// File: rtl/simd_mm_select.sv
module simd_mm_select
    import simd_mm_pkg::*;
#(
    parameter int unsigned NSLICE = 16
) (
    input  logic [NSLICE*SLICE_W-1:0] a,
    input  logic [NSLICE*SLICE_W-1:0] b,
    input  cmp_t [NSLICE-1:0]         lane_cmp,
    input  logic                      take_min,
    input  logic                      quad,
    input  lane_size_e                size,
    output logic [NSLICE*SLICE_W-1:0] result
);
    localparam int unsigned LOW_SLICES = NSLICE / 2;

    for (genvar i = 0; i < NSLICE; i++) begin : g_mux
        logic pick_a, live;
        assign pick_a = take_min ? (!lane_cmp[i].gt && !lane_cmp[i].eq) : lane_cmp[i].gt;
        if (i < LOW_SLICES) begin : g_low
            assign live = (size != SZ_BAD);
        end else begin : g_high
            assign live = (size != SZ_BAD) && quad;
        end
        always_comb begin
            if (!live)
                result[i*SLICE_W +: SLICE_W] = '0;
            else if (pick_a)
                result[i*SLICE_W +: SLICE_W] = a[i*SLICE_W +: SLICE_W];
            else
                result[i*SLICE_W +: SLICE_W] = b[i*SLICE_W +: SLICE_W];
        end
    end
endmodule

// File: rtl/simd_minmax_unit.sv
module simd_minmax_unit
    import simd_mm_pkg::*;
#(
    parameter int unsigned VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [VEC_W-1:0] in_a,
    input  logic [VEC_W-1:0] in_b,
    input  logic             in_op,
    input  logic [1:0]       in_size,
    input  logic             in_u,
    input  logic             in_q,
    output logic             out_valid,
    output logic [VEC_W-1:0] out_result,
    output logic             out_undef
);
    localparam int unsigned NSLICE = VEC_W / SLICE_W;
    localparam int unsigned HALF_W = VEC_W / 2;

    lane_size_e          size_e;
    cmp_t [NSLICE-1:0]   slice_cmp;
    cmp_t [NSLICE-1:0]   lane_cmp;
    logic [VEC_W-1:0]    comb_result;

    assign size_e = lane_size_e'(in_size);

    simd_mm_slice_cmp #(.NSLICE(NSLICE)) u_cmp (
        .a           (in_a),
        .b           (in_b),
        .size        (size_e),
        .is_unsigned (in_u),
        .slice_cmp   (slice_cmp)
    );

    simd_mm_lane_merge #(.NSLICE(NSLICE)) u_merge (
        .slice_cmp (slice_cmp),
        .size      (size_e),
        .lane_cmp  (lane_cmp)
    );

    simd_mm_select #(.NSLICE(NSLICE)) u_sel (
        .a        (in_a),
        .b        (in_b),
        .lane_cmp (lane_cmp),
        .take_min (in_op),
        .quad     (in_q),
        .size     (size_e),
        .result   (comb_result)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_result <= '0;
            out_undef  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result <= comb_result;
                out_undef  <= (size_e == SZ_BAD);
            end
        end
    end

    // latency of one clock for the strobe
    assert_valid_follows_R9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_valid_drops_R9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // reserved size code
    assert_undef_flag_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_size == 2'b11) |=> (out_undef && out_result == '0));

    // short vector keeps the upper half clear
    assert_upper_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_q) |=> (out_result[VEC_W-1:HALF_W] == '0));

    // identical operands come back unchanged for max and min alike
    assert_equal_passthru_R10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_q && in_size != 2'b11 && in_a == in_b) |=> (out_result == $past(in_a)));

endmodule

// File: tb/simd_minmax_unit_bench.sv
module simd_minmax_unit_bench;

    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [127:0] in_a, in_b;
    logic         in_op, in_u, in_q;
    logic [1:0]   in_size;
    logic         out_valid, out_undef;
    logic [127:0] out_result;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    simd_minmax_unit u_simd_minmax_unit (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_a       (in_a),
        .in_b       (in_b),
        .in_op      (in_op),
        .in_size    (in_size),
        .in_u       (in_u),
        .in_q       (in_q),
        .out_valid  (out_valid),
        .out_result (out_result),
        .out_undef  (out_undef)
    );

    // behavioural per-lane model
    function automatic logic [127:0] model(logic op, logic [1:0] sz, logic u, logic q,
                                           logic [127:0] a, logic [127:0] b);
        logic [127:0] r = '0;
        int es, nl;
        longint mask;
        if (sz == 2'b11) return '0;
        es   = 8 << sz;
        nl   = (q ? 128 : 64) / es;
        mask = (longint'(1) << es) - 1;
        for (int e = 0; e < nl; e++) begin
            logic [127:0] sa, sb;
            longint av, bv, rv;
            logic [63:0] rb;
            sa = a >> (e*es);
            sb = b >> (e*es);
            av = longint'({32'b0, sa[31:0]}) & mask;
            bv = longint'({32'b0, sb[31:0]}) & mask;
            if (!u) begin
                if (av >= (longint'(1) << (es-1))) av = av - (longint'(1) << es);
                if (bv >= (longint'(1) << (es-1))) bv = bv - (longint'(1) << es);
            end
            if (op) rv = (av < bv) ? av : bv;
            else    rv = (av > bv) ? av : bv;
            rb = 64'(rv & mask);
            r  = r | ({64'b0, rb} << (e*es));
        end
        return r;
    endfunction

    // lanes cycle through 0, all-ones, most negative, most positive
    function automatic logic [127:0] corners(logic [1:0] sz, int rot);
        logic [127:0] v = '0;
        int es;
        longint mask, val;
        es   = 8 << ((sz == 2'b11) ? 0 : sz);
        mask = (longint'(1) << es) - 1;
        for (int e = 0; e < 128/es; e++) begin
            case ((e + rot) % 4)
                0:       val = 0;
                1:       val = mask;
                2:       val = longint'(1) << (es-1);
                default: val = mask >> 1;
            endcase
            v = v | ({64'b0, 64'(val)} << (e*es));
        end
        return v;
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom(), $urandom(), $urandom(), $urandom()};
    endfunction

    // drive one request after a falling edge, check at the next falling edge
    task automatic apply(logic op, logic [1:0] sz, logic u, logic q,
                         logic [127:0] a, logic [127:0] b, string tag);
        logic [127:0] exp_r;
        logic         exp_undef;
        in_valid = 1'b1; in_op = op; in_size = sz; in_u = u; in_q = q;
        in_a = a; in_b = b;
        exp_r     = model(op, sz, u, q, a, b);
        exp_undef = (sz == 2'b11);
        @(negedge clk);
        n_vec++;
        if (out_valid !== 1'b1 || out_undef !== exp_undef || out_result !== exp_r) begin
            n_fail++;
            $display("FAIL %s op=%0b size=%0b u=%0b q=%0b: got v=%0b undef=%0b res=%h, expected v=1 undef=%0b res=%h",
                     tag, op, sz, u, q, out_valid, out_undef, out_result, exp_undef, exp_r);
        end
    endtask

    task automatic idle(string tag);
        in_valid = 1'b0;
        in_a = rnd128(); in_b = rnd128();
        @(negedge clk);
        n_vec++;
        if (out_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL %s idle cycle: got out_valid=%0b, expected 0", tag, out_valid);
        end
    endtask

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_a = '0; in_b = '0;
        in_op = 1'b0; in_size = 2'b00; in_u = 1'b0; in_q = 1'b0;
        repeat (3) @(negedge clk);
        n_vec++;
        if (out_valid !== 1'b0) begin   // R9 reset state
            n_fail++;
            $display("FAIL R9 reset: got out_valid=%0b, expected 0", out_valid);
        end
        rst = 1'b0;
        idle("R9");

        // R1 R2 R3 R8 R7: every control combination on corner-value lanes
        for (int op = 0; op < 2; op++)
            for (int sz = 0; sz < 4; sz++)
                for (int u = 0; u < 2; u++)
                    for (int q = 0; q < 2; q++)
                        for (int ra = 0; ra < 4; ra++)
                            for (int rb = 0; rb < 4; rb++) begin
                                string tag;
                                if (sz == 3)     tag = "R7";
                                else if (q == 0) tag = "R8";
                                else if (u == 0) tag = "R3";
                                else if (op == 1) tag = "R1";
                                else             tag = "R2";
                                apply(op[0], sz[1:0], u[0], q[0],
                                      corners(sz[1:0], ra), corners(sz[1:0], rb), tag);
                            end

        // R10: identical operands
        for (int i = 0; i < 24; i++) begin
            logic [127:0] v = rnd128();
            apply(i[0], 2'(i % 3), i[1], 1'b1, v, v, "R10");
        end

        // R5: patterns whose wider-lane reading would give a different answer
        for (int sz = 0; sz < 3; sz++)
            for (int op = 0; op < 2; op++)
                for (int u = 0; u < 2; u++) begin
                    apply(op[0], sz[1:0], u[0], 1'b1, {8{16'h00FF}}, {8{16'hFF00}}, "R5");
                    apply(op[0], sz[1:0], u[0], 1'b1, {4{32'h7FFF_8000}}, {4{32'h8000_7FFF}}, "R5");
                    apply(op[0], sz[1:0], u[0], 1'b1, {2{64'h0000_0001_FFFF_FFFF}},
                          {2{64'hFFFF_FFFF_0000_0001}}, "R5");
                end

        // R4 R6: random operands, both vector lengths, back-to-back
        for (int i = 0; i < 400; i++)
            apply(i[0], 2'(i % 3), i[1], i[2], rnd128(), rnd128(), (i[2] ? "R4" : "R6"));

        // R9: idle gaps between requests
        for (int i = 0; i < 6; i++) begin
            idle("R9");
            apply(1'b0, 2'b10, 1'b0, 1'b1, rnd128(), rnd128(), "R9");
        end
        idle("R9");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule